// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block sits behind the fetch buffer of a mainframe-style processor. It receives a 48-bit byte-aligned window whose most significant byte is the first byte of the next instruction. From the top two bits of that byte it works out how long the instruction is, and so how far the fetch logic must advance. It also works out the format class and separates the fields. The five classes are register-register, register-indexed-storage, storage-immediate, storage-storage and storage.

For each memory operand the block forms a 24-bit effective address. The address is a base register, plus an optional index register, plus a zero-extended 12-bit displacement. Register contents come from a 16-entry general register file that is presented as one flat input. A register field of zero adds nothing to the sum. Results are registered and offered with a valid/ready pair. They are held unchanged while the consumer stalls.

Top module: `ivd_decoder`

## Requirements
- R1: `out_len` gives the length in bytes from opcode bits 7:6 of the first window byte. The value 00 gives 2, 01 gives 4, 10 gives 4 and 11 gives 6.
- R2: `out_fmt` gives the class from the same opcode:
  - 00 gives register-register (code 0).
  - 01 gives register-indexed (code 1).
  - 10 with bit 5 clear gives storage-immediate (code 2).
  - 10 with bit 5 set gives storage (code 4).
  - 11 gives storage-storage (code 3).
- R3: Window bytes are numbered from bit 47 down: byte 0 is bits 47:40 and byte 1 is bits 39:32. Fields not used by a class read zero.
  - `out_opcode` is {8'h00, byte 0}. For the storage class it is instead {byte 0, byte 1}.
  - For register-register, `out_r1` is bits 39:36 and `out_r2` is bits 35:32.
  - For register-indexed, `out_r1` is bits 39:36 and `out_r2` is the index field in bits 35:32.
  - `out_imm` is byte 1 for storage-immediate.
  - `out_oplen` is byte 1 for storage-storage.
- R4: For register-indexed, `out_ea1` is the sum of three terms, taken modulo 2^24: the register named by bits 31:28, the register named by bits 35:32, and bits 27:16.
- R5: A base or index field of value 0 adds zero to the sum, not the contents of register 0.
- R6: For storage-immediate and storage, `out_ea1` is the register named by bits 31:28 plus bits 27:16, modulo 2^24. `out_ea_num` is 1 and `out_ea2` is 0.
- R7: For storage-storage, `out_ea1` is formed from bits 31:28 and 27:16. `out_ea2` is formed from bits 15:12 and 11:0. `out_ea_num` is 2.
- R8: For register-register, `out_ea_num`, `out_ea1` and `out_ea2` are all 0.
- R9: `in_ready` is high whenever no result is pending or `out_ready` is high. An accepted window appears at the outputs with `out_valid` high one clock later. Register contents are sampled at acceptance.
- R10: While `out_valid` is high and `out_ready` is low, every output stays unchanged, even if `gpr_flat` or the window changes.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Window is valid |
| in_ready | output | 1 | Block can take a window |
| in_window | input | 48 | Instruction bytes, first byte in bits 47:40 |
| gpr_flat | input | 384 | Register n is in bits 24n+23:24n |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_fmt | output | 3 | Format class code |
| out_len | output | 3 | Instruction length in bytes |
| out_opcode | output | 16 | Opcode, extended for the storage class |
| out_r1 | output | 4 | First register field |
| out_r2 | output | 4 | Second register or index field |
| out_imm | output | 8 | Immediate byte |
| out_oplen | output | 8 | Storage-storage length byte |
| out_ea_num | output | 2 | Number of memory operands |
| out_ea1 | output | 24 | First effective address |
| out_ea2 | output | 24 | Second effective address |

## Verification
`in_ready` is combinational, so it is due in the same cycle that `out_ready` is driven. The bench reads it a moment after driving its inputs at the falling edge. Every decoded field and address is due exactly one rising edge after the window is accepted. The bench therefore compares the outputs at the next falling edge with a reference record, which is computed when the window is accepted and uses the register values of that cycle. During stalls the same record is compared again on each cycle, while the register file and the window keep changing.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int WIN_W   = 48;
  localparam int OPC_W   = 8;
  localparam int REG_W   = 4;
  localparam int DISP_W  = 12;
  localparam int REG_CNT = 1 << REG_W;

  typedef enum logic [2:0] {
    FMT_RR = 3'd0,
    FMT_RX = 3'd1,
    FMT_SI = 3'd2,
    FMT_SS = 3'd3,
    FMT_S  = 3'd4
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [2:0]        len;
    logic [15:0]       opc;
    logic [REG_W-1:0]  r1;
    logic [REG_W-1:0]  r2;
    logic [7:0]        imm;
    logic [7:0]        oplen;
    logic [REG_W-1:0]  base1;
    logic [REG_W-1:0]  index1;
    logic [DISP_W-1:0] disp1;
    logic [REG_W-1:0]  base2;
    logic [DISP_W-1:0] disp2;
    logic              use1;
    logic              use2;
  } fields_t;

  // Class from the first opcode byte.
  function automatic fmt_e fmt_of(input logic [OPC_W-1:0] op);
    case (op[7:6])
      2'b00:   return FMT_RR;
      2'b01:   return FMT_RX;
      2'b10:   return op[5] ? FMT_S : FMT_SI;
      default: return FMT_SS;
    endcase
  endfunction

  // Byte length from the first opcode byte.
  function automatic logic [2:0] len_of(input logic [OPC_W-1:0] op);
    case (op[7:6])
      2'b00:   return 3'd2;
      2'b11:   return 3'd6;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ivd_field_split.sv
module ivd_field_split
  import ivd_pkg::*;
(
  input  logic [WIN_W-1:0] window,
  output fields_t          fields
);
  logic [OPC_W-1:0] op;
  logic [7:0]       byte1;
  assign op    = window[47:40];
  assign byte1 = window[39:32];

  always_comb begin
    fields      = '0;
    fields.fmt  = fmt_of(op);
    fields.len  = len_of(op);
    fields.opc  = {8'h00, op};
    case (fields.fmt)
      FMT_RR: begin
        fields.r1 = window[39:36];
        fields.r2 = window[35:32];
      end
      FMT_RX: begin
        fields.r1     = window[39:36];
        fields.r2     = window[35:32];
        fields.index1 = window[35:32];
        fields.base1  = window[31:28];
        fields.disp1  = window[27:16];
        fields.use1   = 1'b1;
      end
      FMT_SI: begin
        fields.imm   = byte1;
        fields.base1 = window[31:28];
        fields.disp1 = window[27:16];
        fields.use1  = 1'b1;
      end
      FMT_S: begin
        fields.opc   = {op, byte1};
        fields.base1 = window[31:28];
        fields.disp1 = window[27:16];
        fields.use1  = 1'b1;
      end
      default: begin
        fields.oplen = byte1;
        fields.base1 = window[31:28];
        fields.disp1 = window[27:16];
        fields.base2 = window[15:12];
        fields.disp2 = window[11:0];
        fields.use1  = 1'b1;
        fields.use2  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ivd_addr_gen.sv
module ivd_addr_gen
  import ivd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [REG_CNT-1:0][ADDR_W-1:0] regs,
  input  logic [REG_W-1:0]               base,
  input  logic [REG_W-1:0]               index,
  input  logic [DISP_W-1:0]              disp,
  output logic [ADDR_W-1:0]              ea
);
  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] disp_term;

  // Field value 0 means "no register".
  function automatic logic [ADDR_W-1:0] reg_term(
    input logic [REG_CNT-1:0][ADDR_W-1:0] r,
    input logic [REG_W-1:0]               sel
  );
    return (sel == '0) ? '0 : r[sel];
  endfunction

  assign base_term  = reg_term(regs, base);
  assign index_term = reg_term(regs, index);
  assign disp_term  = {{PAD_W{1'b0}}, disp};
  assign ea         = base_term + index_term + disp_term;

  always_comb begin
    if (base == '0 && index == '0) begin
      p_zero_terms_r5: assert (ea == {{PAD_W{1'b0}}, disp});
    end
  end
endmodule

// File: rtl/ivd_decoder.sv
module ivd_decoder
  import ivd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WIN_W-1:0]          in_window,
  input  logic [REG_CNT*ADDR_W-1:0] gpr_flat,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [2:0]                out_fmt,
  output logic [2:0]                out_len,
  output logic [15:0]               out_opcode,
  output logic [REG_W-1:0]          out_r1,
  output logic [REG_W-1:0]          out_r2,
  output logic [7:0]                out_imm,
  output logic [7:0]                out_oplen,
  output logic [1:0]                out_ea_num,
  output logic [ADDR_W-1:0]         out_ea1,
  output logic [ADDR_W-1:0]         out_ea2
);
  localparam int N_OPER = 2;

  logic [REG_CNT-1:0][ADDR_W-1:0] regs;
  fields_t                        fld;
  logic [N_OPER-1:0][ADDR_W-1:0]  ea_raw;
  logic [N_OPER-1:0]              ea_use;

  // Named events for the assertions.
  logic accept;
  logic drain;
  logic stall;

  assign regs = gpr_flat;

  ivd_field_split u_split (
    .window (in_window),
    .fields (fld)
  );

  assign ea_use = {fld.use2, fld.use1};

  for (genvar g = 0; g < N_OPER; g++) begin : g_oper
    ivd_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
      .regs  (regs),
      .base  ((g == 0) ? fld.base1  : fld.base2),
      .index ((g == 0) ? fld.index1 : '0),
      .disp  ((g == 0) ? fld.disp1  : fld.disp2),
      .ea    (ea_raw[g])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign drain    = out_valid && out_ready;
  assign stall    = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fmt    <= '0;
      out_len    <= '0;
      out_opcode <= '0;
      out_r1     <= '0;
      out_r2     <= '0;
      out_imm    <= '0;
      out_oplen  <= '0;
      out_ea_num <= '0;
      out_ea1    <= '0;
      out_ea2    <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_fmt    <= fld.fmt;
      out_len    <= fld.len;
      out_opcode <= fld.opc;
      out_r1     <= fld.r1;
      out_r2     <= fld.r2;
      out_imm    <= fld.imm;
      out_oplen  <= fld.oplen;
      out_ea_num <= 2'($countones(ea_use));
      out_ea1    <= ea_use[0] ? ea_raw[0] : '0;
      out_ea2    <= ea_use[1] ? ea_raw[1] : '0;
    end else if (drain) begin
      out_valid  <= 1'b0;
    end
  end

  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> out_valid && $stable(out_ea1) && $stable(out_ea2)
              && $stable(out_opcode) && $stable(out_len) && $stable(out_fmt));

  p_len_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_fmt == FMT_RR) == (out_len == 3'd2))
                  && ((out_fmt == FMT_SS) == (out_len == 3'd6)));

  p_two_operands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_SS) |-> out_ea_num == 2'd2);

  p_no_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_RR) |-> out_ea_num == 2'd0
                                        && out_ea1 == '0 && out_ea2 == '0);
endmodule

// File: tb/test_ivd_decoder.sv
module test_ivd_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          fmt, len, opc, r1, r2, imm, oplen, num;
    int unsigned ea1, ea2;
    string       eatag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [47:0]  in_window = '0;
  logic [383:0] gpr_flat = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [2:0]   out_fmt, out_len;
  logic [15:0]  out_opcode;
  logic [3:0]   out_r1, out_r2;
  logic [7:0]   out_imm, out_oplen;
  logic [1:0]   out_ea_num;
  logic [23:0]  out_ea1, out_ea2;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  int unsigned gpr_m [16];
  bit          mv = 1'b0;
  bit          held = 1'b0;
  exp_t        me;

  ivd_decoder i_ivd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_window(in_window), .gpr_flat(gpr_flat), .out_valid(out_valid),
    .out_ready(out_ready), .out_fmt(out_fmt), .out_len(out_len),
    .out_opcode(out_opcode), .out_r1(out_r1), .out_r2(out_r2),
    .out_imm(out_imm), .out_oplen(out_oplen), .out_ea_num(out_ea_num),
    .out_ea1(out_ea1), .out_ea2(out_ea2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned term(input int sel);
    return (sel == 0) ? 0 : gpr_m[sel];
  endfunction

  function automatic exp_t ref_dec(input logic [47:0] w);
    exp_t e;
    int op, b1, hi, lo;
    op = int'(w[47:40]); b1 = int'(w[39:32]);
    hi = int'(w[39:36]); lo = int'(w[35:32]);
    e.fmt = 0; e.len = 0; e.opc = op; e.r1 = 0; e.r2 = 0; e.imm = 0;
    e.oplen = 0; e.num = 0; e.ea1 = 0; e.ea2 = 0; e.eatag = "R8";
    if (op < 64) begin
      e.fmt = 0; e.len = 2; e.r1 = hi; e.r2 = lo;
    end else if (op < 128) begin
      e.fmt = 1; e.len = 4; e.r1 = hi; e.r2 = lo; e.num = 1;
      e.ea1 = (term(int'(w[31:28])) + term(lo) + int'(w[27:16])) & 24'hFFFFFF;
      e.eatag = (w[31:28] == 0 || lo == 0) ? "R5" : "R4";
    end else if (op < 192) begin
      e.len = 4; e.num = 1; e.eatag = "R6";
      if (op >= 160) begin e.fmt = 4; e.opc = op * 256 + b1; end
      else begin e.fmt = 2; e.imm = b1; end
      e.ea1 = (term(int'(w[31:28])) + int'(w[27:16])) & 24'hFFFFFF;
    end else begin
      e.fmt = 3; e.len = 6; e.oplen = b1; e.num = 2; e.eatag = "R7";
      e.ea1 = (term(int'(w[31:28])) + int'(w[27:16])) & 24'hFFFFFF;
      e.ea2 = (term(int'(w[15:12])) + int'(w[11:0])) & 24'hFFFFFF;
    end
    return e;
  endfunction

  task automatic compare();
    string h;
    chk("R9 out_valid", out_valid, mv);
    if (mv) begin
      h = held ? "R10 " : "";
      chk({h, "R1 len"}, out_len, me.len);
      chk({h, "R2 fmt"}, out_fmt, me.fmt);
      chk({h, "R3 opcode"}, out_opcode, me.opc);
      chk({h, "R3 r1"}, out_r1, me.r1);
      chk({h, "R3 r2"}, out_r2, me.r2);
      chk({h, "R3 imm"}, out_imm, me.imm);
      chk({h, "R3 oplen"}, out_oplen, me.oplen);
      chk({h, me.eatag, " ea_num"}, out_ea_num, me.num);
      chk({h, me.eatag, " ea1"}, out_ea1, me.ea1);
      chk({h, me.eatag, " ea2"}, out_ea2, me.ea2);
    end
  endtask

  task automatic step(input bit v, input logic [47:0] w, input bit rdy);
    @(negedge clk);
    compare();
    in_valid = v; in_window = w; out_ready = rdy;
    for (int i = 0; i < 16; i++) gpr_flat[i*24 +: 24] = gpr_m[i][23:0];
    #1;
    chk("R9 in_ready", in_ready, !mv || rdy);
    held = mv && !rdy;
    if (v && (!mv || rdy)) begin
      me = ref_dec(w); mv = 1'b1;
    end else if (rdy) begin
      mv = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) gpr_m[i] = i * 32'h111111;
    gpr_m[14] = 24'hFFFFFF; gpr_m[15] = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 in_ready", in_ready, 1);
    rst_n = 1'b1;
    // Directed windows, one per class and corner.
    step(1, 48'h1A35_0000_0000, 1);  // register-register
    step(1, 48'h5A24_7123_0000, 1);  // indexed, both terms
    step(1, 48'h5810_0FFF_0000, 1);  // indexed, base and index 0 (R5)
    step(1, 48'h92AB_6010_0000, 1);  // storage-immediate
    step(1, 48'hB205_9008_0000, 1);  // storage, extended opcode
    step(1, 48'hD20F_1100_0200, 1);  // storage-storage, second base 0
    step(1, 48'h5A0F_EFFF_0000, 1);  // 24-bit wrap (R4)
    step(1, 48'hFF80_EFFF_FABC, 1);  // storage-storage wrap
    // Stall with changing registers and window (R10).
    step(1, 48'h4C3E_D7FF_0000, 0);
    for (int k = 0; k < 4; k++) begin
      gpr_m[13] = $urandom & 24'hFFFFFF;
      gpr_m[14] = $urandom & 24'hFFFFFF;
      step(1, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 0);
    end
    step(0, '0, 1);
    // Random traffic.
    for (int n = 0; n < 2000; n++) begin
      if ($urandom % 3 == 0) gpr_m[$urandom % 16] = $urandom & 24'hFFFFFF;
      step(($urandom % 4) != 0, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF,
           ($urandom % 3) != 0);
    end
    step(0, '0, 1);
    step(0, '0, 1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule